// File: doc/BRIEF.md
# Fetch-Side Branch Predictor with Target Cache and Direction Counters

This block predicts the next fetch address for an in-order pipeline. Every cycle, the fetch stage presents its current program counter. A direct-mapped target cache checks whether that address has been seen before as a taken branch. A separate direction table then decides whether the branch should be followed this time. If the cache misses, the instruction is treated as not a branch and fetch steps to the next sequential word.

When a branch resolves later in the pipeline, the update port returns four things: the branch address, the real outcome, the real destination, and the prediction that was made for it. The block trains its tables from this information. It also raises a mispredict flag, which the surrounding pipeline uses to squash the wrong-path instructions and restart fetch; the squash itself is not done here.

The direction table has no tags and is indexed by low address bits. A parameter chooses one of two history forms for it. The two-bit form uses saturating counters. The one-bit form keeps a last-outcome bit.

Top module: `bpred_unit`

## Requirements
- R1: After reset, every lookup reports no hit and not taken, with the next address equal to the fetch address plus 4.
- R2: On a target cache miss, pred_taken is 0 and pred_npc is fetch_pc + 4 (modulo 2^32), even when the direction state for that index predicts taken.
- R3: A resolved taken branch writes its tag and target into the cache slot chosen by address bits [5:2]. A later lookup of that address hits. A lookup of an address with the same bits [5:2] but different bits [31:6] misses.
- R4: A resolved not-taken branch never allocates or changes a cache entry. A lookup of that address still misses afterwards.
- R5: When the cache hits and the direction state predicts taken, pred_npc equals the stored target.
- R6: In two-bit mode, the counter encoding is 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. Values 2 and 3 predict taken. Each resolved branch moves the counter one step toward its outcome, so a strongly held direction flips only after two opposite outcomes in a row.
- R7: Counters saturate at 0 and 3, and every counter resets to 1.
- R8: When the cache hits but the direction state predicts not taken, pred_hit is 1, pred_taken is 0, and pred_npc is fetch_pc + 4.
- R9: mispredict is 1 only in a cycle with upd_valid set, and only if one of two conditions holds: upd_taken differs from upd_pred_taken, or the branch was taken and upd_target differs from upd_pred_target.
- R10: A lookup in the same cycle as an update to the same entry returns the contents from before the update. The new contents are visible from the next cycle on.
- R11: The direction table has no tag. Branches whose address bits [7:2] match (with 64 entries) share one counter.
- R12: In one-bit mode, each entry holds the last resolved outcome (reset value not taken), so a single opposite outcome flips the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Target cache holds a matching entry |
| pred_taken | output | 1 | Branch predicted taken |
| pred_npc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | PC_W | Actual destination when taken |
| upd_pred_taken | input | 1 | Direction that was predicted for it |
| upd_pred_target | input | PC_W | Next address that was predicted for it |
| mispredict | output | 1 | Wrong-path fetch must be discarded |

## Verification
The bench fills all sixteen cache slots and then probes each slot with an aliasing address. A design that ignored the tag would send those aliases to a stale target.

It walks a counter to both saturation limits and back. A design without saturation would wrap from strong taken to strong not-taken. A one-step-flip design would lose the taken prediction after a single not-taken outcome.

It looks up an entry in the same cycle that entry is rewritten. A write-through design would return the new target one cycle early. It also trains the shared counter through a second address that has a different tag. This exposes a design that wrongly allocates on not-taken outcomes or adds a tag to the direction table. A second instance in one-bit mode is checked in every cycle against its own expected flip behaviour.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   localparam int unsigned INSTR_BYTES = 4;
   localparam int unsigned ALIGN_BITS  = 2;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr2_e;

   // One saturating step toward the resolved outcome.
   function automatic ctr2_e ctr2_step(input ctr2_e cur, input logic taken);
      ctr2_e nxt;
      case (cur)
         CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
         CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
         CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
         default:       nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
      endcase
      return nxt;
   endfunction

   function automatic logic ctr2_predicts_taken(input ctr2_e c);
      return (c == CTR_WEAK_T) || (c == CTR_STRONG_T);
   endfunction

endpackage

// File: rtl/bpred_target_buf.sv
module bpred_target_buf
   import bpred_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_target
);

   localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int unsigned TAG_LSB = IDX_W + ALIGN_BITS;
   localparam int unsigned TAG_W   = PC_W - TAG_LSB;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("bpred_target_buf: ENTRIES must be a power of two, at least 2");
   end
   if (PC_W <= TAG_LSB) begin : g_bad_width
      $error("bpred_target_buf: PC_W too small for the index");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PC_W-1:0]    tgt_q [ENTRIES];

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag;

   assign lk_idx = lk_pc[TAG_LSB-1:ALIGN_BITS];
   assign lk_tag = lk_pc[PC_W-1:TAG_LSB];
   assign wr_idx = wr_pc[TAG_LSB-1:ALIGN_BITS];
   assign wr_tag = wr_pc[PC_W-1:TAG_LSB];

   logic unused_align;
   assign unused_align = &{1'b0, lk_pc[ALIGN_BITS-1:0], wr_pc[ALIGN_BITS-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_target;
      end
   end

   // Reads see the state held before this cycle's write.
   assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_target = tgt_q[lk_idx];

   AST_WRITE_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)]);                                  // R3
   AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && $past(rst_n)) |=> $stable(valid_q));                     // R4

endmodule

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
   import bpred_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ENTRIES   = 64,
   parameter int unsigned HIST_BITS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            upd_en,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int unsigned IDX_HI = IDX_W + ALIGN_BITS - 1;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("bpred_dir_table: ENTRIES must be a power of two, at least 2");
   end
   if (PC_W <= IDX_HI) begin : g_bad_width
      $error("bpred_dir_table: PC_W too small for the index");
   end

   logic [IDX_W-1:0] lk_idx, upd_idx;
   assign lk_idx  = lk_pc[IDX_HI:ALIGN_BITS];
   assign upd_idx = upd_pc[IDX_HI:ALIGN_BITS];

   logic unused_bits;
   assign unused_bits = &{1'b0, lk_pc[PC_W-1:IDX_HI+1], lk_pc[ALIGN_BITS-1:0],
                          upd_pc[PC_W-1:IDX_HI+1], upd_pc[ALIGN_BITS-1:0]};

   if (HIST_BITS == 2) begin : g_two_bit
      ctr2_e ctr_q [ENTRIES];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) ctr_q[i] <= CTR_WEAK_NT;
         end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr2_step(ctr_q[upd_idx], upd_taken);
         end
      end

      assign lk_taken = ctr2_predicts_taken(ctr_q[lk_idx]);

      AST_CTR_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_en && upd_taken && ctr_q[upd_idx] == CTR_STRONG_T)
         |=> ctr_q[$past(upd_idx)] == CTR_STRONG_T);                      // R7
      AST_CTR_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_en && !upd_taken && ctr_q[upd_idx] == CTR_STRONG_NT)
         |=> ctr_q[$past(upd_idx)] == CTR_STRONG_NT);                     // R7
      AST_CTR_NO_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_en && !upd_taken && ctr_q[upd_idx] == CTR_STRONG_T)
         |=> ctr_q[$past(upd_idx)] == CTR_WEAK_T);                        // R6
   end else if (HIST_BITS == 1) begin : g_one_bit
      logic [ENTRIES-1:0] last_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            last_q <= '0;
         end else if (upd_en) begin
            last_q[upd_idx] <= upd_taken;
         end
      end

      assign lk_taken = last_q[lk_idx];

      AST_BIT_TRACKS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
         upd_en |=> last_q[$past(upd_idx)] == $past(upd_taken));          // R12
   end else begin : g_bad_hist
      $error("bpred_dir_table: HIST_BITS must be 1 or 2");
      assign lk_taken = 1'b0;
   end

endmodule

// File: rtl/bpred_unit.sv
module bpred_unit
   import bpred_pkg::*;
#(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned BTB_ENTRIES = 16,
   parameter int unsigned DIR_ENTRIES = 64,
   parameter int unsigned HIST_BITS   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_npc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_pred_taken,
   input  logic [PC_W-1:0] upd_pred_target,
   output logic            mispredict
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   if (PC_W < 8) begin : g_bad_pc
      $error("bpred_unit: PC_W must be at least 8");
   end

   logic            btb_hit;
   logic [PC_W-1:0] btb_target;
   logic            dir_taken;

   bpred_target_buf #(.PC_W(PC_W), .ENTRIES(BTB_ENTRIES)) u_tbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_pc     (fetch_pc),
      .lk_hit    (btb_hit),
      .lk_target (btb_target),
      .wr_en     (upd_valid && upd_taken),
      .wr_pc     (upd_pc),
      .wr_target (upd_target)
   );

   bpred_dir_table #(.PC_W(PC_W), .ENTRIES(DIR_ENTRIES), .HIST_BITS(HIST_BITS)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_pc     (fetch_pc),
      .lk_taken  (dir_taken),
      .upd_en    (upd_valid),
      .upd_pc    (upd_pc),
      .upd_taken (upd_taken)
   );

   assign pred_hit   = btb_hit;
   assign pred_taken = btb_hit && dir_taken;
   assign pred_npc   = pred_taken ? btb_target : fetch_pc + STEP;

   assign mispredict = upd_valid &&
                       ((upd_taken != upd_pred_taken) ||
                        (upd_taken && (upd_target != upd_pred_target)));

   AST_ALLOC_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=> (fetch_pc != $past(upd_pc)) || pred_hit);        // R3
   AST_ALLOC_TARGET_USED: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken)
      |=> (fetch_pc != $past(upd_pc)) || !pred_taken || (pred_npc == $past(upd_target))); // R5
   AST_NOT_TAKEN_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && !pred_hit && fetch_pc == upd_pc)
      |=> (fetch_pc != $past(fetch_pc)) || !pred_hit);                              // R4

endmodule

// File: tb/sim_bpred_unit.sv
`timescale 1ns/1ps
module sim_bpred_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        upd_pred_taken = 1'b0;
   logic [31:0] upd_pred_target = '0;

   logic        hit0, tk0, mp0, hit1, tk1, mp1;
   logic [31:0] npc0, npc1;

   always #2 clk = ~clk;

   bpred_unit u0 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(hit0), .pred_taken(tk0), .pred_npc(npc0),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target), .upd_pred_taken(upd_pred_taken),
      .upd_pred_target(upd_pred_target), .mispredict(mp0)
   );

   bpred_unit #(.HIST_BITS(1)) u1 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(hit1), .pred_taken(tk1), .pred_npc(npc1),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target), .upd_pred_taken(upd_pred_taken),
      .upd_pred_target(upd_pred_target), .mispredict(mp1)
   );

   int tests = 0;
   int fails = 0;

   // Expected state, derived from the requirements.
   bit          m_v   [16];
   logic [25:0] m_tag [16];
   logic [31:0] m_tgt [16];
   int          m_c2  [64];
   int          m_c1  [64];

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic predict(input logic [31:0] pc, input bit one_bit,
                          output logic h, output logic t, output logic [31:0] n);
      int bi, di;
      bi = int'(pc[5:2]);
      di = int'(pc[7:2]);
      h  = m_v[bi] && (m_tag[bi] == pc[31:6]);
      t  = h && (one_bit ? (m_c1[di] != 0) : (m_c2[di] >= 2));
      n  = t ? m_tgt[bi] : pc + 32'd4;
   endtask

   task automatic cycle(input string tag, input logic [31:0] fpc, input logic uv,
                        input logic [31:0] upc, input logic ut, input logic [31:0] utgt);
      logic ph, pt, eh, et, emp;
      logic [31:0] pn, en;
      int bi, di;
      @(negedge clk);
      fetch_pc   = fpc;
      upd_valid  = uv;
      upd_pc     = upc;
      upd_taken  = ut;
      upd_target = utgt;
      predict(upc, 1'b0, ph, pt, pn);
      upd_pred_taken  = pt;
      upd_pred_target = pn;
      #1;
      predict(fpc, 1'b0, eh, et, en);
      check(tag, {30'd0, hit0, tk0, npc0}, {30'd0, eh, et, en});
      predict(fpc, 1'b1, eh, et, en);
      check("R12", {30'd0, hit1, tk1, npc1}, {30'd0, eh, et, en});
      emp = uv && ((ut != pt) || (ut && (utgt != pn)));
      check("R9", {63'd0, mp0}, {63'd0, emp});
      check("R9", {63'd0, mp1}, {63'd0, emp});
      @(posedge clk);
      if (uv) begin
         di = int'(upc[7:2]);
         m_c2[di] = ut ? ((m_c2[di] < 3) ? m_c2[di] + 1 : 3)
                       : ((m_c2[di] > 0) ? m_c2[di] - 1 : 0);
         m_c1[di] = ut ? 1 : 0;
         if (ut) begin
            bi = int'(upc[5:2]);
            m_v[bi]   = 1'b1;
            m_tag[bi] = upc[31:6];
            m_tgt[bi] = utgt;
         end
      end
   endtask

   task automatic step(input string tag, input logic [31:0] pc, input logic t,
                       input logic [31:0] tgt);
      cycle(tag, pc, 1'b1, pc, t, tgt);
      cycle(tag, pc, 1'b0, 32'd0, 1'b0, 32'd0);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
      end
      for (int i = 0; i < 64; i++) begin
         m_c2[i] = 1; m_c1[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty tables after reset
      for (int i = 0; i < 16; i++)
         cycle("R1", 32'h1000 + 32'(4 * i), 1'b0, 32'd0, 1'b0, 32'd0);

      // R4: a not-taken outcome never allocates
      cycle("R4", 32'h2080, 1'b1, 32'h2080, 1'b0, 32'h5555_0000);
      cycle("R4", 32'h2080, 1'b0, 32'd0, 1'b0, 32'd0);
      cycle("R4", 32'h1000, 1'b0, 32'd0, 1'b0, 32'd0);

      // R3: fill every target slot with a taken branch
      for (int i = 0; i < 16; i++)
         cycle("R3", 32'h3000, 1'b1, 32'h1000 + 32'(4 * i), 1'b1, 32'h8000 + 32'(64 * i));

      // R5 hits on each slot; R3 aliases with a different tag miss
      for (int i = 0; i < 16; i++) begin
         cycle("R5", 32'h1000 + 32'(4 * i), 1'b0, 32'd0, 1'b0, 32'd0);
         cycle("R3", 32'h1040 + 32'(4 * i), 1'b0, 32'd0, 1'b0, 32'd0);
      end

      // R2: miss at the top of the address space wraps
      cycle("R2", 32'hFFFF_FFFC, 1'b0, 32'd0, 1'b0, 32'd0);
      cycle("R2", 32'h2080, 1'b0, 32'd0, 1'b0, 32'd0);

      // R9 mispredict on direction, then R8 hit predicted not taken
      cycle("R9", 32'h1000, 1'b1, 32'h1000, 1'b0, 32'd0);
      cycle("R8", 32'h1000, 1'b0, 32'd0, 1'b0, 32'd0);

      // R7 saturation and R6 two-step flip on one counter
      step("R7", 32'h1004, 1'b1, 32'h8040);
      step("R7", 32'h1004, 1'b1, 32'h8040);
      step("R6", 32'h1004, 1'b0, 32'd0);
      step("R6", 32'h1004, 1'b0, 32'd0);
      step("R7", 32'h1004, 1'b0, 32'd0);
      step("R7", 32'h1004, 1'b0, 32'd0);
      step("R6", 32'h1004, 1'b1, 32'h8040);
      step("R6", 32'h1004, 1'b1, 32'h8040);

      // R10: same-cycle lookup of a rewritten entry returns the old target
      step("R10", 32'h1008, 1'b1, 32'h8080);
      cycle("R10", 32'h1008, 1'b1, 32'h1008, 1'b1, 32'h9000);
      cycle("R10", 32'h1008, 1'b0, 32'd0, 1'b0, 32'd0);

      // R11: a differently tagged branch trains the shared counter
      cycle("R11", 32'h1010, 1'b1, 32'h1110, 1'b0, 32'd0);
      cycle("R11", 32'h1010, 1'b1, 32'h1110, 1'b0, 32'd0);
      cycle("R11", 32'h1010, 1'b0, 32'd0, 1'b0, 32'd0);

      @(negedge clk);
      upd_valid = 1'b0;
      summary();
      $finish;
   end

endmodule